// File: doc/BRIEF.md
# Two-Key Register Write Protection Gate

This block guards the write path of a peripheral register bank. Software unlocks it by storing two fixed 32-bit key words into two dedicated key registers. The order of the two stores does not matter. While both key registers hold their correct words, the gate is open: `bank_wr_ok` qualifies writes to the protected registers elsewhere in the bank, and the gate's own scratch words accept writes. Storing any other word into either key register, zero included, closes the gate again.

Three 32-bit scratch words live behind the same gate. Reads are never blocked. The read data returns the current contents of the key and scratch registers at the addressed word, whatever the lock state.

Top module: `kick_gate`

## Requirements
- R1: After reset the gate is locked, all three scratch words read 0x00000000, and both key registers read 0x00000000.
- R2: The gate is open exactly when key register A (byte address 0x6C) holds 0x83E70B13 and key register B (byte address 0x70) holds 0x95A4F1E0. Either write order works. The gate opens in the cycle after the second correct key is captured.
- R3: With only one of the two key registers holding its correct word, the gate stays locked.
- R4: Writing 0x00000000 or any other wrong word to either key register locks the gate from the next cycle.
- R5: While the gate is open, a full-word write to a scratch address (0x60, 0x64 or 0x68) is stored, and it reads back from the next cycle.
- R6: While the gate is locked, a scratch write is dropped and the scratch word keeps its previous value.
- R7: Reads are combinational and never blocked. `bus_rdata` shows the addressed key or scratch register in the same cycle, and shows zero for any other address.
- R8: `bank_wr_ok` is high only in a cycle where `bus_wr` is high, the gate is open, and `bus_addr` is not one of the gate's own five addresses.
- R9: Writes to the key registers are always captured, whatever the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| bank_wr_ok | output | 1 | Qualified write enable for the protected registers |

## Verification
`bus_rdata` and `bank_wr_ok` are combinational from the address, the strobe and the stored state. They are valid in the same cycle that their inputs change. A write is captured at the next rising edge. The stored value, or the new lock state, is seen at the outputs from the cycle after that write. The bench drives every input on the falling edge and samples 1 ns later. Each write task returns only after the capturing rising edge. Strobe probes of `bank_wr_ok` raise `bus_wr` and drop it again before any rising edge, so a probe changes no state.

// File: rtl/kick_gate_pkg.sv
package kick_gate_pkg;
    localparam int unsigned WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;
    localparam word_t KEY_A_MAGIC = 32'h83E7_0B13;
    localparam word_t KEY_B_MAGIC = 32'h95A4_F1E0;
endpackage

// File: rtl/kick_gate_decode.sv
module kick_gate_decode
    import kick_gate_pkg::*;
#(
    parameter int unsigned        ADDR_W     = 8,
    parameter int unsigned        NUM_SCR    = 3,
    parameter logic [ADDR_W-1:0]  SCR_BASE   = 8'h60,
    parameter logic [ADDR_W-1:0]  KEYA_ADDR  = 8'h6C,
    parameter logic [ADDR_W-1:0]  KEYB_ADDR  = 8'h70
) (
    input  logic [ADDR_W-1:0]         addr,
    input  word_t                     key_a,
    input  word_t                     key_b,
    input  word_t [NUM_SCR-1:0]       scr_words,
    output logic  [NUM_SCR-1:0]       scr_hit,
    output logic  [1:0]               key_hit,
    output logic                      own_hit,
    output word_t                     rdata
);
    localparam int unsigned STRIDE = WORD_W / 8;

    for (genvar i = 0; i < NUM_SCR; i++) begin : g_hit
        localparam logic [ADDR_W-1:0] WORD_ADDR = ADDR_W'(SCR_BASE + STRIDE * i);
        assign scr_hit[i] = (addr == WORD_ADDR);
    end

    assign key_hit[0] = (addr == KEYA_ADDR);
    assign key_hit[1] = (addr == KEYB_ADDR);
    assign own_hit    = (|scr_hit) | (|key_hit);

    always_comb begin
        rdata = '0;
        if (key_hit[0]) rdata = key_a;
        if (key_hit[1]) rdata = key_b;
        for (int i = 0; i < NUM_SCR; i++) begin
            if (scr_hit[i]) rdata = scr_words[i];
        end
    end
endmodule

// File: rtl/kick_gate_keys.sv
module kick_gate_keys
    import kick_gate_pkg::*;
#(
    parameter word_t KEYA_VAL = KEY_A_MAGIC,
    parameter word_t KEYB_VAL = KEY_B_MAGIC
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [1:0] key_hit,
    input  word_t      wdata,
    output word_t      key_a,
    output word_t      key_b,
    output logic       unlocked
);
    typedef struct packed {
        word_t [1:0] slot;
    } key_state_t;

    key_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < 2; i++) begin
            if (wr && key_hit[i]) st_d.slot[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign key_a    = st_q.slot[0];
    assign key_b    = st_q.slot[1];
    assign unlocked = (st_q.slot[0] == KEYA_VAL) && (st_q.slot[1] == KEYB_VAL);
endmodule

// File: rtl/kick_gate_scratch.sv
module kick_gate_scratch
    import kick_gate_pkg::*;
#(
    parameter int unsigned NUM_SCR = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_ok,
    input  logic [NUM_SCR-1:0]   scr_hit,
    input  word_t                wdata,
    output word_t [NUM_SCR-1:0]  words
);
    typedef struct packed {
        word_t [NUM_SCR-1:0] w;
    } scr_state_t;

    scr_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_SCR; i++) begin
            if (wr_ok && scr_hit[i]) st_d.w[i] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign words = st_q.w;
endmodule

// File: rtl/kick_gate.sv
module kick_gate
    import kick_gate_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        NUM_SCR   = 3,
    parameter logic [ADDR_W-1:0]  SCR_BASE  = 8'h60,
    parameter logic [ADDR_W-1:0]  KEYA_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0]  KEYB_ADDR = 8'h70,
    parameter word_t              KEYA_VAL  = KEY_A_MAGIC,
    parameter word_t              KEYB_VAL  = KEY_B_MAGIC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bank_wr_ok
);
    word_t                 key_a, key_b;
    word_t [NUM_SCR-1:0]   scr_words;
    logic  [NUM_SCR-1:0]   scr_hit;
    logic  [1:0]           key_hit;
    logic                  own_hit;
    logic                  unlocked;
    logic                  scr_wr_ok;

    kick_gate_decode #(
        .ADDR_W(ADDR_W), .NUM_SCR(NUM_SCR), .SCR_BASE(SCR_BASE),
        .KEYA_ADDR(KEYA_ADDR), .KEYB_ADDR(KEYB_ADDR)
    ) u_decode (
        .addr(bus_addr), .key_a(key_a), .key_b(key_b), .scr_words(scr_words),
        .scr_hit(scr_hit), .key_hit(key_hit), .own_hit(own_hit), .rdata(bus_rdata)
    );

    kick_gate_keys #(
        .KEYA_VAL(KEYA_VAL), .KEYB_VAL(KEYB_VAL)
    ) u_keys (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .key_hit(key_hit), .wdata(bus_wdata),
        .key_a(key_a), .key_b(key_b), .unlocked(unlocked)
    );

    assign scr_wr_ok = bus_wr & unlocked;

    kick_gate_scratch #(
        .NUM_SCR(NUM_SCR)
    ) u_scratch (
        .clk(clk), .rst_n(rst_n), .wr_ok(scr_wr_ok), .scr_hit(scr_hit),
        .wdata(bus_wdata), .words(scr_words)
    );

    assign bank_wr_ok = bus_wr & unlocked & ~own_hit;
endmodule

// File: rtl/kick_gate_chk.sv
module kick_gate_chk
    import kick_gate_pkg::*;
#(
    parameter int unsigned        ADDR_W    = 8,
    parameter int unsigned        NUM_SCR   = 3,
    parameter logic [ADDR_W-1:0]  SCR_BASE  = 8'h60,
    parameter logic [ADDR_W-1:0]  KEYA_ADDR = 8'h6C,
    parameter logic [ADDR_W-1:0]  KEYB_ADDR = 8'h70,
    parameter word_t              KEYA_VAL  = KEY_A_MAGIC,
    parameter word_t              KEYB_VAL  = KEY_B_MAGIC
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    bus_wr,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [31:0]             bus_wdata,
    input logic                    bank_wr_ok,
    input logic                    unlocked,
    input word_t                   key_a,
    input word_t                   key_b,
    input logic [NUM_SCR*32-1:0]   scr_flat
);
    // R1: leaving reset, gate closed and scratch cleared
    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!unlocked && scr_flat == '0));

    // R8: qualified write only with strobe and both keys correct
    p_gate_needs_keys_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr_ok |-> (bus_wr && key_a == KEYA_VAL && key_b == KEYB_VAL));

    // R4: a wrong word into key A closes the gate
    p_wrong_key_relock_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == KEYA_ADDR && bus_wdata != KEYA_VAL) |=> !unlocked);

    // R5: open gate stores scratch word 0
    p_scratch_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && unlocked && bus_addr == SCR_BASE) |=> (scr_flat[31:0] == $past(bus_wdata)));

    // R6: without an open-gate write the scratch words hold
    p_scratch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && unlocked) |=> $stable(scr_flat));

    // R9: key B captures regardless of lock state
    p_key_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == KEYB_ADDR) |=> (key_b == $past(bus_wdata)));
endmodule

bind kick_gate kick_gate_chk #(
    .ADDR_W(ADDR_W), .NUM_SCR(NUM_SCR), .SCR_BASE(SCR_BASE),
    .KEYA_ADDR(KEYA_ADDR), .KEYB_ADDR(KEYB_ADDR),
    .KEYA_VAL(KEYA_VAL), .KEYB_VAL(KEYB_VAL)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bank_wr_ok(bank_wr_ok), .unlocked(unlocked),
    .key_a(key_a), .key_b(key_b), .scr_flat(scr_words)
);

// File: tb/kick_gate_bench.sv
`timescale 1ns/1ps
module kick_gate_bench;
    localparam logic [31:0] KA = 32'h83E7_0B13;
    localparam logic [31:0] KB = 32'h95A4_F1E0;
    localparam logic [7:0]  A_KA = 8'h6C, A_KB = 8'h70;
    localparam logic [7:0]  A_S0 = 8'h60, A_S1 = 8'h64, A_S2 = 8'h68;
    localparam logic [7:0]  A_EXT = 8'h00, A_NONE = 8'h74;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bank_wr_ok;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    kick_gate u_kick_gate (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bank_wr_ok(bank_wr_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    // strobe probe: raise and drop bus_wr between rising edges
    task automatic probe(input string req, input logic [7:0] a, input logic strobe, input logic exp);
        @(negedge clk);
        bus_addr = a; bus_wr = strobe; bus_wdata = 32'hDEAD_BEEF;
        #1;
        check(req, {31'd0, bank_wr_ok}, {31'd0, exp});
        bus_wr = 1'b0;
    endtask

    task automatic t_reset();
        rd_check("R1 scratch0", A_S0, 32'h0);
        rd_check("R1 scratch1", A_S1, 32'h0);
        rd_check("R1 scratch2", A_S2, 32'h0);
        rd_check("R1 keyA", A_KA, 32'h0);
        rd_check("R1 keyB", A_KB, 32'h0);
        probe("R1 locked", A_EXT, 1'b1, 1'b0);
    endtask

    task automatic t_locked_drop();
        wr(A_S1, 32'hA5A5_5A5A);
        rd_check("R6 dropped", A_S1, 32'h0);
        probe("R8 locked", A_EXT, 1'b1, 1'b0);
    endtask

    task automatic t_one_key();
        wr(A_KA, KA);
        rd_check("R9 keyA captured", A_KA, KA);
        probe("R3 one key", A_EXT, 1'b1, 1'b0);
        wr(A_KA, 32'h0);
        wr(A_KB, KB);
        probe("R3 only keyB", A_EXT, 1'b1, 1'b0);
    endtask

    task automatic t_unlock_orders();
        wr(A_KA, KA);
        probe("R2 B then A", A_EXT, 1'b1, 1'b1);
        wr(A_KA, 32'h0);
        wr(A_KB, 32'h0);
        probe("R4 zeros lock", A_EXT, 1'b1, 1'b0);
        wr(A_KA, KA);
        wr(A_KB, KB);
        probe("R2 A then B", A_EXT, 1'b1, 1'b1);
    endtask

    task automatic t_scratch();
        wr(A_S0, 32'h1111_0000);
        wr(A_S1, 32'h2222_0001);
        wr(A_S2, 32'h3333_0002);
        rd_check("R5 scratch0", A_S0, 32'h1111_0000);
        rd_check("R5 scratch1", A_S1, 32'h2222_0001);
        rd_check("R5 scratch2", A_S2, 32'h3333_0002);
    endtask

    task automatic t_own_addr();
        probe("R8 scratch addr", A_S0, 1'b1, 1'b0);
        probe("R8 keyA addr", A_KA, 1'b1, 1'b0);
        probe("R8 keyB addr", A_KB, 1'b1, 1'b0);
        probe("R8 no strobe", A_EXT, 1'b0, 1'b0);
        probe("R8 other addr", A_NONE, 1'b1, 1'b1);
    endtask

    task automatic t_relock();
        wr(A_KA, 32'h0);
        probe("R4 zero keyA", A_EXT, 1'b1, 1'b0);
        wr(A_S0, 32'hFFFF_FFFF);
        rd_check("R6 hold after relock", A_S0, 32'h1111_0000);
        rd_check("R7 read while locked", A_S2, 32'h3333_0002);
        rd_check("R7 unmapped", A_NONE, 32'h0);
        wr(A_KA, KA);
        probe("R2 reopen", A_EXT, 1'b1, 1'b1);
        wr(A_KB, 32'h0000_1234);
        probe("R4 wrong keyB", A_EXT, 1'b1, 1'b0);
        rd_check("R9 keyB captured", A_KB, 32'h0000_1234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_locked_drop();
        t_one_key();
        t_unlock_orders();
        t_scratch();
        t_own_addr();
        t_relock();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule